// File: doc/BRIEF.md
# Manchester Serial Word Receiver with Digital Clock Recovery

This block takes the serial Manchester stream from one redundant bus and turns it into 16-bit words. It is clocked by a sampling clock that takes `SAMPLES_PER_BIT` samples per bit: 10 at the 10 Mb/s rate with a 100 MHz clock. The line first passes through a two-flop synchronizer. A run-length counter then looks for a sync pattern: two halves of 1.5 bit times each, at opposite levels. The centre transition of the sync pattern sets the phase of a digital phase-locked loop. That loop keeps a per-bit phase counter aligned to the mid-bit transitions and moves it by one count whenever a transition arrives early or late.

The bit cells that follow the sync are sampled once in each half. Each cell is checked for its mid-cell transition, and its bits are shifted in most significant bit first. The cell after the last data bit carries the parity bit. When a word completes, the block gives exactly one of three single-cycle strobes: a clean word, a parity error, or a coding error. A chip with two buses uses two instances of this block, one per bus.

Top module: `mdec_rx`

## Requirements
- R1: After reset, `rxWord` is 0, `rxIsCmd` is 0, and none of `wordValid`, `parityErr` or `manchErr` is asserted until a word has been received.
- R2: A sync whose first half is high and second half is low sets `rxIsCmd` to 1. A sync that is low then high sets it to 0.
- R3: Each bit cell carries a 1 as high-then-low and a 0 as low-then-high. The first cell after the sync becomes bit 15 of `rxWord`. `rxWord` changes only in a cycle where `wordValid` or `parityErr` is high.
- R4: The cell after the 16 data bits is the parity bit. If the 17 bits hold an odd number of ones, the block pulses `wordValid`. Otherwise it pulses `parityErr`, and `rxWord`/`rxIsCmd` still take the new word.
- R5: A bit cell, parity cell included, with no level change between its halves makes the block pulse `manchErr`. In that case `rxWord` and `rxIsCmd` keep their previous values.
- R6: Each received word produces exactly one strobe, one cycle long, in the cycle after its last cell ends. The three strobes are never high together.
- R7: Each sync half is accepted when it lasts between 1.5 bit times minus one sample and 1.5 bit times plus one sample (14 to 16 samples by default). A first half of 17 samples, or a second half that ends at 13 samples, produces no strobe.
- R8: Mid-bit transitions displaced by up to one sample from the cell centre, varying cell by cell, are decoded without error.
- R9: A sender whose bit cells are one sample longer, or one sample shorter, than nominal across the whole word is decoded without error.
- R10: Two words sent back to back with no idle gap between them are both decoded. This holds whether or not the level changes at the boundary between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, `SAMPLES_PER_BIT` cycles per bit |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Serial Manchester line from the bus receiver |
| rxWord | output | DATA_BITS | Last word accepted (clean or parity error) |
| rxIsCmd | output | 1 | 1 when that word had a command/status sync |
| wordValid | output | 1 | One-cycle strobe: word received with good coding and parity |
| parityErr | output | 1 | One-cycle strobe: good coding, wrong parity |
| manchErr | output | 1 | One-cycle strobe: a cell without its mid transition, word dropped |

## Verification
The bench builds the block with its defaults: 10 samples per bit and 16 data bits. With these values a sync half is 15 samples, the tolerance band is 14 to 16 samples, and the phase window covers two samples on each side of the cell centre. A one-sample shift of the mid transition, and a sender running at 9 or 11 samples per cell, therefore sit exactly at the limits the loop has to follow. The short parity word also lets the bench place a coding error in the first cell, in a middle cell and in the parity cell.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [1:0] {
    ST_HUNT      = 2'd0,
    ST_SYNC_TAIL = 2'd1,
    ST_BITS      = 2'd2
  } mdecState_e;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic wordStart;   // sync centre accepted
    logic cmdSync;     // sync type of the word being started
    logic takeFirst;   // sample first half of cell
    logic takeSecond;  // sample second half of cell
    logic cellDone;    // last phase of a cell
    logic wordDone;    // last phase of the parity cell
  } mdecCtl_t;

endpackage

// File: rtl/mdec_insync.sv
module mdec_insync (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  output logic rxLvl,
  output logic rxEdge
);

  logic [1:0] meta;
  logic       prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta    <= 2'b00;
      prevLvl <= 1'b0;
    end else begin
      meta    <= {meta[0], rxIn};
      prevLvl <= meta[1];
    end
  end

  assign rxLvl  = meta[1];
  assign rxEdge = meta[1] ^ prevLvl;

endmodule

// File: rtl/mdec_ctrl.sv
module mdec_ctrl
  import mdec_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 10,
  parameter int DATA_BITS       = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxLvl,
  input  logic     rxEdge,
  output mdecCtl_t ctl
);

  localparam int HALF     = SAMPLES_PER_BIT / 2;
  localparam int SYNC_LEN = SAMPLES_PER_BIT + HALF;
  localparam int WIN      = SAMPLES_PER_BIT / 4;
  localparam int Q1       = HALF / 2;
  localparam int Q3       = HALF + HALF / 2;
  localparam int CELLS    = DATA_BITS + 1;
  localparam int PH_W     = $clog2(SAMPLES_PER_BIT);
  localparam int CNT_W    = $clog2(SYNC_LEN + 1);
  localparam int RUN_W    = $clog2(2 * SYNC_LEN + 1);
  localparam int CELL_W   = $clog2(CELLS + 1);

  localparam logic [RUN_W-1:0]  RUN_LO   = RUN_W'(SYNC_LEN - 1);
  localparam logic [RUN_W-1:0]  RUN_HI   = RUN_W'(SYNC_LEN + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = '1;
  localparam logic [CNT_W-1:0]  TAIL_END = CNT_W'(SYNC_LEN - 1);
  localparam logic [PH_W-1:0]   PH_MID   = PH_W'(HALF);
  localparam logic [PH_W-1:0]   PH_ELO   = PH_W'(HALF - WIN);
  localparam logic [PH_W-1:0]   PH_LHI   = PH_W'(HALF + WIN);
  localparam logic [PH_W-1:0]   PH_Q1    = PH_W'(Q1);
  localparam logic [PH_W-1:0]   PH_Q3    = PH_W'(Q3);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(SAMPLES_PER_BIT - 1);
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(CELLS - 1);

  mdecState_e        state;
  logic [PH_W-1:0]   ph;
  logic [CNT_W-1:0]  syncCnt;
  logic [CELL_W-1:0] cellCnt;
  logic [RUN_W-1:0]  runLen;

  logic inSyncWin;
  logic phEarly;
  logic phLate;
  logic lastPh;
  logic inBits;

  assign inSyncWin = (runLen >= RUN_LO) && (runLen <= RUN_HI);
  assign phEarly   = rxEdge && (ph >= PH_ELO) && (ph < PH_MID);
  assign phLate    = rxEdge && (ph > PH_MID) && (ph <= PH_LHI);
  assign lastPh    = (ph == PH_LAST);
  assign inBits    = (state == ST_BITS);

  always_comb begin
    ctl            = '0;
    ctl.wordStart  = (state == ST_HUNT) && rxEdge && inSyncWin;
    ctl.cmdSync    = !rxLvl;
    ctl.takeFirst  = inBits && (ph == PH_Q1);
    ctl.takeSecond = inBits && (ph == PH_Q3);
    ctl.cellDone   = inBits && lastPh;
    ctl.wordDone   = inBits && lastPh && (cellCnt == CELL_LAST);
  end

  // Sequencer and phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      ph      <= '0;
      syncCnt <= '0;
      cellCnt <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (ctl.wordStart) begin
            state   <= ST_SYNC_TAIL;
            syncCnt <= CNT_W'(1);
          end
        end
        ST_SYNC_TAIL: begin
          if (rxEdge && (syncCnt < TAIL_END)) begin
            state <= ST_HUNT;
          end else if (syncCnt == TAIL_END) begin
            state   <= ST_BITS;
            ph      <= rxEdge ? PH_W'(1) : '0;
            cellCnt <= '0;
          end else begin
            syncCnt <= syncCnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (lastPh) begin
            ph      <= '0;
            cellCnt <= cellCnt + 1'b1;
            if (cellCnt == CELL_LAST) state <= ST_HUNT;
          end else if (phEarly) begin
            ph <= ph + PH_W'(2);
          end else if (!phLate) begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // Length of the current line level, restarted at each word end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (rxEdge) begin
      runLen <= RUN_W'(1);
    end else if (ctl.wordDone) begin
      runLen <= '0;
    end else if (runLen != RUN_MAX) begin
      runLen <= runLen + 1'b1;
    end
  end

endmodule

// File: rtl/mdec_datapath.sv
module mdec_datapath
  import mdec_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLvl,
  input  mdecCtl_t             ctl,
  output logic [DATA_BITS-1:0] rxWord,
  output logic                 rxIsCmd,
  output logic                 wordValid,
  output logic                 parityErr,
  output logic                 manchErr
);

  logic [DATA_BITS-1:0] shiftR;
  logic                 halfA;
  logic                 halfB;
  logic                 parAcc;
  logic                 manchBad;
  logic                 typeCmd;
  logic                 parFinal;
  logic                 badFinal;

  assign parFinal = parAcc ^ halfA;
  assign badFinal = manchBad | (halfA == halfB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftR    <= '0;
      halfA     <= 1'b0;
      halfB     <= 1'b0;
      parAcc    <= 1'b0;
      manchBad  <= 1'b0;
      typeCmd   <= 1'b0;
      rxWord    <= '0;
      rxIsCmd   <= 1'b0;
      wordValid <= 1'b0;
      parityErr <= 1'b0;
      manchErr  <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      parityErr <= 1'b0;
      manchErr  <= 1'b0;
      if (ctl.wordStart) begin
        shiftR   <= '0;
        parAcc   <= 1'b0;
        manchBad <= 1'b0;
        typeCmd  <= ctl.cmdSync;
      end
      if (ctl.takeFirst)  halfA <= rxLvl;
      if (ctl.takeSecond) halfB <= rxLvl;
      if (ctl.cellDone) begin
        if (ctl.wordDone) begin
          if (badFinal) begin
            manchErr <= 1'b1;
          end else begin
            rxWord  <= shiftR;
            rxIsCmd <= typeCmd;
            if (parFinal) wordValid <= 1'b1;
            else          parityErr <= 1'b1;
          end
        end else begin
          shiftR   <= {shiftR[DATA_BITS-2:0], halfA};
          parAcc   <= parAcc ^ halfA;
          manchBad <= manchBad | (halfA == halfB);
        end
      end
    end
  end

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
  import mdec_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 10,
  parameter int DATA_BITS       = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  output logic [DATA_BITS-1:0] rxWord,
  output logic                 rxIsCmd,
  output logic                 wordValid,
  output logic                 parityErr,
  output logic                 manchErr
);

  logic     rxLvl;
  logic     rxEdge;
  mdecCtl_t ctl;

  mdec_insync u_insync (
    .clk    (clk),
    .rstN   (rstN),
    .rxIn   (rxIn),
    .rxLvl  (rxLvl),
    .rxEdge (rxEdge)
  );

  mdec_ctrl #(
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
    .DATA_BITS       (DATA_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rxLvl  (rxLvl),
    .rxEdge (rxEdge),
    .ctl    (ctl)
  );

  mdec_datapath #(
    .DATA_BITS (DATA_BITS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .rxLvl     (rxLvl),
    .ctl       (ctl),
    .rxWord    (rxWord),
    .rxIsCmd   (rxIsCmd),
    .wordValid (wordValid),
    .parityErr (parityErr),
    .manchErr  (manchErr)
  );

endmodule

// File: rtl/mdec_chk.sv
module mdec_chk
  import mdec_pkg::*;
#(
  parameter int DATA_BITS = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_BITS-1:0] rxWord,
  input logic                 rxIsCmd,
  input logic                 wordValid,
  input logic                 parityErr,
  input logic                 manchErr,
  input mdecCtl_t             ctl
);

  logic anyStrobe;
  assign anyStrobe = wordValid | parityErr | manchErr;

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wordValid, parityErr, manchErr}));

  // R6
  strobe_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wordDone |=> anyStrobe);

  // R6
  strobe_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> $past(ctl.wordDone));

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !anyStrobe);

  // R5
  manch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    manchErr |-> ($stable(rxWord) && $stable(rxIsCmd)));

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid || parityErr) |-> $stable(rxWord));

endmodule

bind mdec_rx mdec_chk #(.DATA_BITS(DATA_BITS)) u_mdec_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rxWord    (rxWord),
  .rxIsCmd   (rxIsCmd),
  .wordValid (wordValid),
  .parityErr (parityErr),
  .manchErr  (manchErr),
  .ctl       (ctl)
);

// File: tb/test_mdec_rx.sv
module test_mdec_rx;

  localparam int SPB   = 10;
  localparam int DBITS = 16;
  localparam int SYNC  = 15;

  logic             clk  = 1'b0;
  logic             rstN = 1'b0;
  logic             rxIn = 1'b0;
  logic [DBITS-1:0] rxWord;
  logic             rxIsCmd;
  logic             wordValid;
  logic             parityErr;
  logic             manchErr;

  always #4 clk = ~clk;

  mdec_rx #(.SAMPLES_PER_BIT(SPB), .DATA_BITS(DBITS)) i_mdec_rx (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .rxWord    (rxWord),
    .rxIsCmd   (rxIsCmd),
    .wordValid (wordValid),
    .parityErr (parityErr),
    .manchErr  (manchErr)
  );

  int nChecks  = 0;
  int nErrors  = 0;
  int seenV    = 0;
  int seenP    = 0;
  int seenM    = 0;
  logic [DBITS-1:0] capLast = '0;
  logic [DBITS-1:0] capPrev = '0;
  logic             cmdLast = 1'b0;
  logic             cmdPrev = 1'b0;

  // Strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (wordValid) seenV++;
      if (parityErr) seenP++;
      if (manchErr)  seenM++;
      if (wordValid || parityErr) begin
        capPrev <= capLast;
        capLast <= rxWord;
        cmdPrev <= cmdLast;
        cmdLast <= rxIsCmd;
      end
    end
  end

  logic [DBITS-1:0] expWord = '0;
  logic             expCmd  = 1'b0;

  function automatic logic oddParBit(input logic [DBITS-1:0] d);
    return ~^d;
  endfunction

  function automatic int kindCode(input int v, input int p, input int m);
    return v * 100 + p * 10 + m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    rxIn = lvl;
    repeat (n) @(negedge clk);
  endtask

  // mode 0 nominal, 1 mid jitter, 2 slow cells, 3 fast cells
  task automatic sendWord(input bit cmd, input logic [DBITS-1:0] data,
                          input bit badPar, input int manIdx, input int mode,
                          input int syncA, input int syncB, input bit lead);
    logic firstLvl;
    logic par;
    firstLvl = cmd;
    par = oddParBit(data) ^ badPar;
    if (lead) hold(~firstLvl, 25);
    hold(firstLvl, syncA);
    hold(~firstLvl, syncB);
    for (int i = 0; i <= DBITS; i++) begin
      logic b;
      int   a;
      int   l;
      b = (i < DBITS) ? data[DBITS-1-i] : par;
      case (mode)
        1: begin a = 4 + int'($urandom % 3); l = 10; end
        2: begin a = 6; l = 11; end
        3: begin a = 4; l = 9; end
        default: begin a = 5; l = 10; end
      endcase
      if (i == manIdx) hold(b, l);
      else begin
        hold(b, a);
        hold(~b, l - a);
      end
    end
  endtask

  task automatic runCase(input string req, input bit cmd, input logic [DBITS-1:0] data,
                         input bit badPar, input int manIdx, input int mode,
                         input int syncA, input int syncB, input bit expectNone);
    int v0, p0, m0, got, exp;
    v0 = seenV; p0 = seenP; m0 = seenM;
    sendWord(cmd, data, badPar, manIdx, mode, syncA, syncB, 1'b1);
    hold(rxIn, 30);
    got = kindCode(seenV - v0, seenP - p0, seenM - m0);
    if (expectNone || manIdx >= 0) begin
      exp = expectNone ? 0 : 1;
    end else begin
      exp = badPar ? 10 : 100;
      expWord = data;
      expCmd  = cmd;
    end
    chk(got == exp, req, "strobe kind", got, exp);
    chk(rxWord == expWord, req, "word", int'(rxWord), int'(expWord));
    chk(rxIsCmd == expCmd, req, "type", int'(rxIsCmd), int'(expCmd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rxIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    // R1 reset state
    chk(rxWord == '0, "R1", "reset word", int'(rxWord), 0);
    chk(rxIsCmd == 1'b0, "R1", "reset type", int'(rxIsCmd), 0);
    chk(seenV + seenP + seenM == 0, "R1", "reset strobes", seenV + seenP + seenM, 0);

    // R2 / R3 basic command and data words
    runCase("R2", 1'b1, 16'hA5C3, 1'b0, -1, 0, SYNC, SYNC, 1'b0);
    runCase("R2", 1'b0, 16'h3C5A, 1'b0, -1, 0, SYNC, SYNC, 1'b0);
    runCase("R3", 1'b1, 16'hFFFF, 1'b0, -1, 0, SYNC, SYNC, 1'b0);
    runCase("R3", 1'b0, 16'h0000, 1'b0, -1, 0, SYNC, SYNC, 1'b0);
    runCase("R3", 1'b1, 16'h8001, 1'b0, -1, 0, SYNC, SYNC, 1'b0);

    // R4 parity error still updates the word
    runCase("R4", 1'b0, 16'h1234, 1'b1, -1, 0, SYNC, SYNC, 1'b0);
    runCase("R4", 1'b1, 16'h0F0F, 1'b1, -1, 0, SYNC, SYNC, 1'b0);

    // R5 missing mid transition in first, middle and parity cells
    runCase("R5", 1'b0, 16'hBEEF, 1'b0, 0, 0, SYNC, SYNC, 1'b0);
    runCase("R5", 1'b1, 16'h4242, 1'b0, 7, 0, SYNC, SYNC, 1'b0);
    runCase("R5", 1'b0, 16'h7777, 1'b0, 16, 0, SYNC, SYNC, 1'b0);

    // R7 sync tolerance edges
    runCase("R7", 1'b1, 16'h1111, 1'b0, -1, 0, 14, SYNC, 1'b0);
    runCase("R7", 1'b0, 16'h2222, 1'b0, -1, 0, 16, SYNC, 1'b0);
    runCase("R7", 1'b1, 16'hC000, 1'b0, -1, 0, SYNC, 14, 1'b0);
    runCase("R7", 1'b0, 16'h4444, 1'b0, -1, 0, SYNC, 16, 1'b0);
    runCase("R7", 1'b1, 16'h9999, 1'b0, -1, 0, 17, 13, 1'b1);
    runCase("R7", 1'b1, 16'hF0F0, 1'b0, -1, 0, SYNC, 13, 1'b1);
    runCase("R7", 1'b0, 16'h6666, 1'b0, -1, 0, SYNC, SYNC, 1'b0);

    // R8 mid-bit jitter
    for (int k = 0; k < 4; k++)
      runCase("R8", k[0], 16'($urandom), 1'b0, -1, 1, SYNC, SYNC, 1'b0);

    // R9 sender rate offset
    runCase("R9", 1'b1, 16'hD00D, 1'b0, -1, 2, SYNC, SYNC, 1'b0);
    runCase("R9", 1'b0, 16'h5AA5, 1'b0, -1, 3, SYNC, SYNC, 1'b0);
    runCase("R9", 1'b1, 16'h0001, 1'b0, -1, 2, SYNC, SYNC, 1'b0);
    runCase("R9", 1'b0, 16'hFFFE, 1'b0, -1, 3, SYNC, SYNC, 1'b0);

    // R10 back-to-back pairs: merged level, then level change at boundary
    for (int k = 0; k < 2; k++) begin
      int v0;
      logic [DBITS-1:0] wa;
      logic [DBITS-1:0] wb;
      wa = (k == 0) ? 16'h0000 : 16'h0001;
      wb = 16'hC3A7 ^ 16'(k);
      v0 = seenV;
      sendWord(1'b1, wa, 1'b0, -1, 0, SYNC, SYNC, 1'b1);
      sendWord(1'b0, wb, 1'b0, -1, 0, SYNC, SYNC, 1'b0);
      hold(rxIn, 30);
      chk(seenV - v0 == 2, "R10", "valid count", seenV - v0, 2);
      chk(capPrev == wa && cmdPrev == 1'b1, "R10", "first word", int'(capPrev), int'(wa));
      chk(capLast == wb && cmdLast == 1'b0, "R10", "second word", int'(capLast), int'(wb));
      expWord = wb;
      expCmd  = 1'b0;
    end

    // R6 constrained random mix of all cases
    for (int k = 0; k < 40; k++) begin
      bit cmd;
      bit badPar;
      int manIdx;
      int mode;
      cmd    = 1'($urandom);
      badPar = ($urandom % 6) == 0;
      manIdx = (($urandom % 6) == 0) ? int'($urandom % 17) : -1;
      mode   = int'($urandom % 4);
      runCase("R6", cmd, 16'($urandom), badPar, manIdx, mode, SYNC, SYNC, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule